// File: doc/BRIEF.md
# Counting or Pseudo-Random Word Source

This block produces one word per enabled clock cycle for a memory self-test engine, which uses the words as write data or as addresses. It holds two independent sources side by side: a binary up-counter and a Fibonacci linear-feedback shift register. The state width of the shift register and its feedback tap positions are set by parameters.

A mode input chooses which source drives the output word. It can change at any time. The choice only steers the output. Both sources step together on every cycle in which the advance input is high, and both hold still when it is low. When the output is narrower than the shift register, the output carries the low-order bits of the register state.

The default build has a 23-bit output and a 23-bit register state. The feedback taps sit at state bits 22 and 17, which gives a maximal-length sequence.

Top module: `wordsrc`

## Requirements
- R1: While `rst` is high, `word_o` is 0 when `rnd_en` is 0 and equals the low `OUT_W` bits of `SEED` when `rnd_en` is 1. The default `SEED` is 1.
- R2: In counting mode (`rnd_en`=0) with `adv` held high after reset, `word_o` shows 0, 1, 2, … on successive cycles with no gaps or repeats.
- R3: The counter is `OUT_W` bits wide and wraps from 2^`OUT_W`−1 back to 0.
- R4: On each advance, the register state moves one place toward the MSB. The new bit 0 is the XOR of the state bits selected by the ones in `TAP_MASK`. The default mask is 23'h420000, which selects bits 22 and 17.
- R5: On a cycle with `adv` low, neither the counter nor the register changes. This is seen at `word_o` in both modes.
- R6: The counter and the register both advance on every enabled cycle, whatever the mode. After N enabled cycles in one mode, switching mode shows the other source's Nth value in the same cycle, with no extra latency.
- R7: When `OUT_W` < `STATE_W`, `word_o` in random mode shows state bits [`OUT_W`−1:0].
- R8: In the default build, 1024 successive random-mode outputs are all distinct and none is zero.
- R9: A reset during a run takes priority over `adv` and returns both sources to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance: both sources step at this cycle's edge |
| rnd_en | input | 1 | Mode: 0 selects the counter, 1 selects the shift register |
| word_o | output | OUT_W | Current word |

## Verification
The bench checks the counter wrap on a 3-bit build. A counter that wrapped early or stuck at its maximum would break the ramp there. A mode switch after a long counting run must show a shift-register value that has advanced by the full run; a design that stepped only the selected source would show the seed instead. Long hold stretches with advance low catch a source that creeps. A reset asserted together with advance catches a design that lets the step win. A 4-bit register feeding a 3-bit output shows whether the low bits, rather than the high bits, are presented.

// File: rtl/wordsrc.sv
module wordsrc #(
  parameter int STATE_W = 23,
  parameter int OUT_W   = 23,
  parameter logic [STATE_W-1:0] TAP_MASK = 23'h42_0000,
  parameter logic [STATE_W-1:0] SEED     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             rnd_en,
  output logic [OUT_W-1:0] word_o
);

  logic [OUT_W-1:0]   cnt_q;
  logic [STATE_W-1:0] lfsr_q;
  logic               fb;

  assign fb = ^(lfsr_q & TAP_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lfsr_q <= SEED;
    end else if (adv) begin
      cnt_q  <= cnt_q + 1'b1;
      lfsr_q <= {lfsr_q[STATE_W-2:0], fb};
    end
  end

  assign word_o = rnd_en ? lfsr_q[OUT_W-1:0] : cnt_q;

endmodule

// File: rtl/wordsrc_chk.sv
module wordsrc_chk #(
  parameter int STATE_W = 23,
  parameter int OUT_W   = 23
) (
  input logic               clk,
  input logic               rst,
  input logic               adv,
  input logic [OUT_W-1:0]   cnt_q,
  input logic [STATE_W-1:0] lfsr_q
);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(cnt_q) && $stable(lfsr_q)));                                    // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cnt_q == OUT_W'($past(cnt_q) + 1'b1)));                                  // R2
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    adv |=> (lfsr_q[STATE_W-1:1] == $past(lfsr_q[STATE_W-2:0])));                     // R4
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);                                                                    // R8
  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));                                                           // R9

endmodule

bind wordsrc wordsrc_chk #(.STATE_W(STATE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .cnt_q(cnt_q), .lfsr_q(lfsr_q)
);

// File: tb/wordsrc_tb.sv
module wordsrc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic rnd_en = 1'b0;
  logic [22:0] word_o;
  logic [2:0]  sword_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [22:0] m_cnt, m_lfsr;
  logic [2:0]  m_scnt;
  logic [3:0]  m_slfsr;
  logic [22:0] seen [1024];

  always #2.5 clk = ~clk;

  wordsrc u_dut (.clk(clk), .rst(rst), .adv(adv), .rnd_en(rnd_en), .word_o(word_o));

  wordsrc #(.STATE_W(4), .OUT_W(3), .TAP_MASK(4'b1100), .SEED(4'b0001)) u_dut_small (
    .clk(clk), .rst(rst), .adv(adv), .rnd_en(rnd_en), .word_o(sword_o));

  function automatic logic [22:0] nxt23(logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [3:0] nxt4(logic [3:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (rst) begin
      m_cnt = 0; m_lfsr = 1; m_scnt = 0; m_slfsr = 1;
    end else if (adv) begin
      m_cnt++; m_lfsr = nxt23(m_lfsr); m_scnt++; m_slfsr = nxt4(m_slfsr);
    end
  endtask

  initial begin
    m_cnt = 0; m_lfsr = 1; m_scnt = 0; m_slfsr = 1;
    repeat (3) step();
    chk(word_o == 0, "R1", 32'(word_o), 0);
    rnd_en = 1'b1; #1;
    chk(word_o == 23'd1, "R1", 32'(word_o), 1);
    chk(sword_o == 3'd1, "R1", 32'(sword_o), 1);
    rnd_en = 1'b0; #1;
    rst = 1'b0;
    adv = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      chk(word_o == 23'(i), "R2", 32'(word_o), 32'(i));
      chk(sword_o == m_scnt, "R3", 32'(sword_o), 32'(m_scnt));
      step();
    end
    rnd_en = 1'b1; #1;
    chk(word_o == m_lfsr && m_lfsr != 1, "R6", 32'(word_o), 32'(m_lfsr));
    for (int i = 0; i < 1024; i++) begin
      chk(word_o == m_lfsr, "R4", 32'(word_o), 32'(m_lfsr));
      chk(sword_o == m_slfsr[2:0], "R7", 32'(sword_o), 32'(m_slfsr[2:0]));
      seen[i] = word_o;
      step();
    end
    begin
      int dups = 0;
      int zeros = 0;
      for (int i = 0; i < 1024; i++) begin
        if (seen[i] == 0) zeros++;
        for (int j = i + 1; j < 1024; j++) if (seen[i] == seen[j]) dups++;
      end
      chk(dups == 0 && zeros == 0, "R8", 32'(dups + zeros), 0);
    end
    adv = 1'b0;
    for (int k = 0; k < 6; k++) begin
      rnd_en = k[0]; #1;
      chk(word_o == (k[0] ? m_lfsr : m_cnt), "R5", 32'(word_o), 32'(k[0] ? m_lfsr : m_cnt));
      chk(sword_o == (k[0] ? m_slfsr[2:0] : m_scnt), "R5", 32'(sword_o),
          32'(k[0] ? m_slfsr[2:0] : m_scnt));
      step();
    end
    rnd_en = 1'b0;
    adv = 1'b1;
    repeat (5) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    adv = 1'b0; #1;
    chk(word_o == 0, "R9", 32'(word_o), 0);
    rnd_en = 1'b1; #1;
    chk(word_o == 1, "R9", 32'(word_o), 1);
    adv = 1'b1;
    step();
    chk(word_o == 23'd2 && m_lfsr == 23'd2, "R9", 32'(word_o), 2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule